// File: doc/BRIEF.md
# Packet Payload XOR Cipher Stage

This block sits in a packet data path as a streaming stage. Packets move through it one bus word per beat, with start and end markers, a byte-valid field for the last word, and a valid/ready handshake on both sides. The block leaves the leading header words of each packet as they are. It XORs every later word with a mask, which is a 32-bit secret key repeated across the bus width.

XOR with the same key undoes itself, so one design serves both directions. One instance encrypts frames going out toward the network. Another instance with the same key decrypts frames arriving from it.

Software loads the key through a one-cycle write port. A new key is held pending and becomes active only at the start of a packet. A packet is therefore never split between two keys.

Top module: `pkt_xor_stage`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0.
- R2: A word accepted on the input (`in_valid` and `in_ready` high at a clock edge) is presented on the output with `out_valid` high right after that same edge. The stage has exactly one cycle of latency.
- R3: While `out_valid` is high and `out_ready` is low, every output port holds its value. `in_ready` is low in that state.
- R4: The first `HDR_WORDS` words of a packet leave unchanged. The word marked by `in_sop` counts as word 0.
- R5: Every packet word from index `HDR_WORDS` onward leaves as `in_data ^ {key, key}`. Key bits [31:0] land on data bits [31:0] and on data bits [63:32].
- R6: `out_sop`, `out_eop` and `out_be` carry the accepted word's `in_sop`, `in_eop` and `in_be` unchanged.
- R7: A packet of `HDR_WORDS` words or fewer leaves completely unchanged.
- R8: A key written through `key_wr_en`/`key_wr_data` is used from the first start-of-packet word accepted in a later cycle. The words of a packet already in progress keep the key that was active at that packet's start.
- R9: Two instances in series, loaded with the same key, return every packet word equal to the original.
- R10: After reset the key is zero, so payload words pass unchanged until a key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take a word |
| in_data | input | DATA_W | Input word |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_be | input | DATA_W/8 | Byte-valid field of input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_be | output | DATA_W/8 | Byte-valid field, forwarded |
| key_wr_en | input | 1 | Key write strobe |
| key_wr_data | input | KEY_W | Key value to hold pending |

## Verification
Each result is due one clock edge after its input word is accepted. While downstream stalls, the result is due again after every edge until `out_ready` lets it go.

The bench drives inputs on the falling edge and then records whether the word will be accepted. On the next falling edge it checks that the output is present and compares it with the reference word. A key write is credited to the model at the edge it is driven for, so a key change is expected from the next packet start seen after that edge.

The chained pair is checked two edges after each accepted word.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  // Next value of a word counter that stops at lim
  function automatic int sat_inc(input int cur, input int lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // A word index lies in the header region when below the header length
  function automatic bit in_header(input int idx, input int hdr_words);
    return idx < hdr_words;
  endfunction

endpackage

// File: rtl/pxs_key_bank.sv
module pxs_key_bank #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             commit,
  output logic [KEY_W-1:0] key_now,
  output logic [KEY_W-1:0] active_key
);
  logic [KEY_W-1:0] pending_q;
  logic [KEY_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      active_q  <= '0;
    end else begin
      if (wr_en)  pending_q <= wr_key;
      if (commit) active_q  <= pending_q;
    end
  end

  assign key_now    = commit ? pending_q : active_q;
  assign active_key = active_q;
endmodule

// File: rtl/pxs_pos_track.sv
module pxs_pos_track #(
  parameter int HDR_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic sop,
  output logic is_hdr
);
  import pxs_pkg::*;
  localparam int CNT_W = $clog2(HDR_WORDS + 1);

  logic [CNT_W-1:0] cnt_q;
  int idx;

  always_comb begin
    idx    = sop ? 0 : int'(cnt_q);
    is_hdr = in_header(idx, HDR_WORDS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (adv) cnt_q <= CNT_W'(sat_inc(idx, HDR_WORDS));
  end
endmodule

// File: rtl/pxs_pipe_reg.sv
module pxs_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         take,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q       <= d;
    end else if (take) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_xor_stage.sv
module pkt_xor_stage #(
  parameter int DATA_W    = 64,
  parameter int KEY_W     = 32,
  parameter int HDR_WORDS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [DATA_W/8-1:0] in_be,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_sop,
  output logic                out_eop,
  output logic [DATA_W/8-1:0] out_be,
  input  logic                key_wr_en,
  input  logic [KEY_W-1:0]    key_wr_data
);
  localparam int BE_W   = DATA_W / 8;
  localparam int REPS   = DATA_W / KEY_W;
  localparam int BEAT_W = DATA_W + BE_W + 2;

  function automatic logic [DATA_W-1:0] spread_key(input logic [KEY_W-1:0] k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < REPS; i++) m[i*KEY_W +: KEY_W] = k;
    return m;
  endfunction

  // Named internal events, used by the checker
  logic              acc;
  logic              sop_acc;
  logic              payload_word;
  logic [KEY_W-1:0]  key_now;
  logic [KEY_W-1:0]  active_key;
  logic [DATA_W-1:0] mask_now;
  logic [BEAT_W-1:0] beat_d, beat_q;
  logic              is_hdr;

  assign in_ready     = !out_valid || out_ready;
  assign acc          = in_valid && in_ready;
  assign sop_acc      = acc && in_sop;
  assign payload_word = !is_hdr;

  pxs_key_bank #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr_en), .wr_key(key_wr_data),
    .commit(sop_acc), .key_now(key_now), .active_key(active_key)
  );

  pxs_pos_track #(.HDR_WORDS(HDR_WORDS)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(acc), .sop(in_sop), .is_hdr(is_hdr)
  );

  assign mask_now = payload_word ? spread_key(key_now) : '0;
  assign beat_d   = {in_sop, in_eop, in_be, in_data ^ mask_now};

  pxs_pipe_reg #(.W(BEAT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(acc), .take(out_ready),
    .d(beat_d), .q(beat_q), .q_valid(out_valid)
  );

  assign out_sop  = beat_q[BEAT_W-1];
  assign out_eop  = beat_q[BEAT_W-2];
  assign out_be   = beat_q[DATA_W +: BE_W];
  assign out_data = beat_q[DATA_W-1:0];
endmodule

// File: rtl/pxs_chk.sv
module pxs_chk #(
  parameter int DATA_W = 64,
  parameter int KEY_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc,
  input logic                payload_word,
  input logic                in_sop,
  input logic                in_eop,
  input logic [DATA_W/8-1:0] in_be,
  input logic [DATA_W-1:0]   in_data,
  input logic [KEY_W-1:0]    key_now,
  input logic [KEY_W-1:0]    active_key,
  input logic                key_wr_en,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_data,
  input logic                out_sop,
  input logic                out_eop,
  input logic [DATA_W/8-1:0] out_be
);
  localparam int REPS = DATA_W / KEY_W;

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_sop) && $stable(out_eop) && $stable(out_be));

  // R4
  header_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !payload_word |=> out_data == $past(in_data));

  // R4
  sop_is_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_sop |-> !payload_word);

  // R6
  side_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_sop == $past(in_sop) && out_eop == $past(in_eop) &&
      out_be == $past(in_be));

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_sop) |=> $stable(active_key));

  genvar g;
  generate
    for (g = 0; g < REPS; g++) begin : g_slice
      // R5
      payload_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && payload_word |=>
          out_data[g*KEY_W +: KEY_W] == ($past(in_data[g*KEY_W +: KEY_W]) ^ $past(key_now)));
    end
  endgenerate
endmodule

bind pkt_xor_stage pxs_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .payload_word(payload_word),
  .in_sop(in_sop), .in_eop(in_eop), .in_be(in_be), .in_data(in_data),
  .key_now(key_now), .active_key(active_key), .key_wr_en(key_wr_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop), .out_be(out_be)
);

// File: tb/pkt_xor_stage_bench.sv
module pkt_xor_stage_bench;
  localparam int DW = 64;
  localparam int KW = 32;
  localparam int HW = 2;
  localparam int BW = DW / 8;

  typedef struct {
    logic [DW-1:0] data;
    logic          sop, eop;
    logic [BW-1:0] be;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0, key_wr_en = 0;
  logic [DW-1:0] in_data = '0;
  logic [BW-1:0] in_be = '0;
  logic [KW-1:0] key_wr_data = '0;
  logic          in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [BW-1:0] out_be;

  pkt_xor_stage #(.DATA_W(DW), .KEY_W(KW), .HDR_WORDS(HW)) u_pkt_xor_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_be(in_be),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_be(out_be),
    .key_wr_en(key_wr_en), .key_wr_data(key_wr_data));

  // Chained pair: encrypt then decrypt, fed with every word the main stage accepts
  logic          c_in_valid, e_rdy, e_v, e_sop, e_eop, d_rdy, d_v, d_sop, d_eop;
  logic [DW-1:0] e_data, d_data;
  logic [BW-1:0] e_be, d_be;
  assign c_in_valid = in_valid && in_ready;

  pkt_xor_stage #(.DATA_W(DW), .KEY_W(KW), .HDR_WORDS(HW)) u_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(e_rdy),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_be(in_be),
    .out_valid(e_v), .out_ready(d_rdy), .out_data(e_data),
    .out_sop(e_sop), .out_eop(e_eop), .out_be(e_be),
    .key_wr_en(key_wr_en), .key_wr_data(key_wr_data));
  pkt_xor_stage #(.DATA_W(DW), .KEY_W(KW), .HDR_WORDS(HW)) u_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(e_v), .in_ready(d_rdy),
    .in_data(e_data), .in_sop(e_sop), .in_eop(e_eop), .in_be(e_be),
    .out_valid(d_v), .out_ready(1'b1), .out_data(d_data),
    .out_sop(d_sop), .out_eop(d_eop), .out_be(d_be),
    .key_wr_en(key_wr_en), .key_wr_data(key_wr_data));

  int errors = 0, checks = 0;
  exp_t q_main[$];
  logic [DW-1:0] q_chain[$];
  logic [KW-1:0] m_pending = '0, m_active = '0;
  int   m_idx = 0, pkt_len = 0;
  bit   due_next = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model step for a word about to be accepted at the coming edge
  task automatic model_accept();
    exp_t e;
    int   idx;
    logic [KW-1:0] k;
    idx = in_sop ? 0 : m_idx;
    if (in_sop) m_active = m_pending;
    k = m_active;
    e.sop = in_sop; e.eop = in_eop; e.be = in_be;
    if (idx < HW) begin
      e.data = in_data;
      e.tag  = (pkt_len <= HW) ? "R7" : "R4";
    end else begin
      e.data = in_data ^ {k, k};
      e.tag  = (k == '0) ? "R10 R5" : "R5 R8";
    end
    q_main.push_back(e);
    q_chain.push_back(in_data);
    m_idx = idx + 1;
  endtask

  // One cycle: check at the falling edge, then drive, then model
  task automatic cycle(input bit v, input bit s, input bit eo, input logic [DW-1:0] d,
                       input logic [BW-1:0] b, input bit rdy, input bit kw,
                       input logic [KW-1:0] kd);
    logic [DW-1:0] prev_data;
    @(negedge clk);
    if (due_next) check(out_valid === 1'b1, "R2 out_valid", DW'(out_valid), 1);
    if (out_valid) begin
      if (q_main.size() == 0) check(0, "R2 unexpected word", out_data, 0);
      else begin
        check(out_data === q_main[0].data, q_main[0].tag, out_data, q_main[0].data);
        check({out_sop, out_eop, out_be} === {q_main[0].sop, q_main[0].eop, q_main[0].be},
              "R6", DW'({out_sop, out_eop, out_be}),
              DW'({q_main[0].sop, q_main[0].eop, q_main[0].be}));
      end
    end
    if (d_v) begin
      if (q_chain.size() == 0) check(0, "R9 unexpected word", d_data, 0);
      else begin
        // bytes beyond out_be on a last word are masked from the comparison
        logic [DW-1:0] msk;
        for (int i = 0; i < BW; i++) msk[i*8 +: 8] = {8{d_be[i] | !d_eop}};
        check((d_data & msk) === (q_chain[0] & msk), "R9", d_data, q_chain[0]);
        void'(q_chain.pop_front());
      end
    end
    prev_data = out_data;
    in_valid = v; in_sop = s; in_eop = eo; in_data = d; in_be = b;
    out_ready = rdy; key_wr_en = kw; key_wr_data = kd;
    #1;
    if (out_valid && !out_ready) begin
      check(!in_ready, "R3 in_ready", DW'(in_ready), 0);
    end
    if (out_valid && out_ready) void'(q_main.pop_front());
    due_next = in_valid && in_ready;
    if (due_next) model_accept();
    if (kw) m_pending = kd;
  endtask

  task automatic send_pkt(input int len, input int stall_pct, input bit kw_mid,
                          input logic [KW-1:0] kd);
    int i = 0;
    pkt_len = len;
    while (i < len) begin
      bit rdy = ($urandom_range(99) >= stall_pct);
      bit eo  = (i == len - 1);
      logic [BW-1:0] b = eo ? BW'($urandom) | BW'(1) : '1;
      bit kw = kw_mid && (i == 1);
      cycle(1, i == 0, eo, {$urandom, $urandom}, b, rdy, kw, kd);
      if (due_next) i++;
    end
    cycle(0, 0, 0, '0, '0, 1, 0, '0);
  endtask

  // Stall hold check at the ports
  logic [DW-1:0] held;
  task automatic stall_test();
    pkt_len = 4;
    cycle(1, 1, 0, 64'h1111_2222_3333_4444, '1, 0, 0, '0);
    cycle(0, 0, 0, '0, '0, 0, 0, '0);
    held = out_data;
    cycle(0, 0, 0, '0, '0, 0, 0, '0);
    check(out_valid && out_data === held, "R3 hold", out_data, held);
    cycle(1, 0, 0, 64'h5, '1, 1, 0, '0);
    cycle(1, 0, 0, 64'h6, '1, 1, 0, '0);
    cycle(1, 0, 1, 64'h7, '1, 1, 0, '0);
    cycle(0, 0, 0, '0, '0, 1, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 in reset", DW'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 after reset", DW'(out_valid), 0);
    send_pkt(5, 0, 0, '0);                    // R10 key still zero
    cycle(0, 0, 0, '0, '0, 1, 1, 32'hA5C3_0F1E);
    send_pkt(6, 0, 1, 32'h1234_5678);         // R8 key write mid-packet
    send_pkt(4, 0, 0, '0);                    // R8 new key now active
    send_pkt(1, 0, 0, '0);                    // R7
    send_pkt(2, 0, 0, '0);                    // R7
    stall_test();
    for (int p = 0; p < 300; p++) begin
      bit kw = ($urandom_range(4) == 0);
      send_pkt($urandom_range(1, 9), 35, kw, $urandom);
    end
    repeat (4) cycle(0, 0, 0, '0, '0, 1, 0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule